// File: doc/BRIEF.md
# Network Message Transmit Packer

The packer sits between a 64-bit transmit queue and a byte-wide network link. Each outgoing request in the queue begins with a descriptor word. For some message kinds a word holding the source bus address follows it. The payload words come last. The block turns that request into a byte stream: a four-byte header, then an eight-byte address preamble when the message kind calls for one, then the payload. Every byte leaves on a 9-bit link as eight data bits plus an odd-parity bit, under a valid/ready handshake.

The packer pops the queue one word at a time and splits each word into bytes internally. It stalls on an empty queue and on a link that is not ready. It enforces a 128-byte ceiling on the whole message. A request that asks for more payload than fits is cut at the ceiling, the header reports the shortened length, and the surplus payload words are pulled from the queue and discarded. Truncation is flagged with a one-cycle error pulse.

Top module: `msg_tx_packer`

## Requirements
- R1: While reset is low and in the first cycle after it, `tx_valid` and `trunc_err` are 0. When idle after reset, `q_ready` is 1.
- R2: The descriptor word carries the destination in bits [7:0], the requested payload size in bytes in bits [15:8], the message kind in bits [18:16] and the source ID in bits [31:24]. The header goes out in the order destination, transmitted payload size, kind (zero-extended to a byte), source ID.
- R3: Kinds 0 (write), 1 (read), 4 (block transfer) and 5 (block transfer reply) take the next queue word as the source address. That address is sent as 8 bytes, least significant byte first, straight after the header.
- R4: Kinds 2 (write reply) and 3 (read reply) carry no preamble. Their payload follows the header directly.
- R5: Payload words are consumed as ceil(size/8) queue words. Bytes are sent least significant first, and the unused upper lanes of the last word are never sent.
- R6: `tx_data[7:0]` is the byte and `tx_data[8]` makes the count of ones over all nine bits odd.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds its value and `tx_valid` stays 1. No byte is dropped or repeated.
- R8: An empty queue stalls the packer without inventing bytes. The queue is never popped in a cycle in which a byte is offered.
- R9: If header plus preamble plus requested payload exceeds 128 bytes, the payload is cut so that the message is exactly 128 bytes. The header size byte shows the cut length. The remaining payload words are popped and discarded, and the next message is framed correctly.
- R10: `trunc_err` pulses high for exactly one cycle, in the cycle when the first header byte of a truncated message is first offered, and never for a message that fits.
- R11: A size of 0 yields the header alone, or the header and preamble for kinds that carry one, and pops no payload words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_data | input | 64 | Head word of the transmit queue |
| q_valid | input | 1 | Queue holds a word |
| q_ready | output | 1 | Packer pops the head word this cycle |
| tx_data | output | 9 | Parity bit (bit 8) and data byte |
| tx_valid | output | 1 | A byte is offered on the link |
| tx_ready | input | 1 | Link accepts the offered byte |
| trunc_err | output | 1 | One-cycle pulse for a truncated request |

## Verification
The truncation pulse and the first header byte of the same message fall in the same cycle, and that is the cycle in which the link may be back-pressured. The bench provokes the overlap by dropping `tx_ready` whenever it sees the pulse. It then judges that the pulse lasts a single cycle, coincides with the stream position where a new message begins, and belongs only to truncated messages. It also judges that the held header byte is delivered once and unchanged. The whole message table runs twice, once with no stalls and once with pseudo-random gaps on both the queue and the link. A reset is also applied in the middle of a message.

// File: rtl/msg_tx_packer.sv
module msg_tx_packer #(
  parameter int WORD_W        = 64,
  parameter int MAX_MSG_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] q_data,
  input  logic              q_valid,
  output logic              q_ready,
  output logic [8:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              trunc_err
);
  localparam int BPW       = WORD_W / 8;
  localparam int BI_W      = $clog2(BPW);
  localparam int HDR_BYTES = 4;
  localparam int LIM_NOPRE = MAX_MSG_BYTES - HDR_BYTES;
  localparam int LIM_PRE   = LIM_NOPRE - BPW;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PRE, S_DATA, S_DRAIN} st_t;

  st_t              st;
  logic [31:0]      hdr;
  logic [1:0]       hcnt;
  logic             has_pre;
  logic [WORD_W-1:0] wbuf;
  logic             wfull;
  logic [BI_W-1:0]  bidx;
  logic [7:0]       dleft;
  logic [8:0]       pop_left;

  logic [7:0] d_dest, d_size, d_src, d_eff;
  logic [2:0] d_type;
  logic       d_pre, d_over;
  logic [8:0] d_lim, d_words;

  assign d_dest  = q_data[7:0];
  assign d_size  = q_data[15:8];
  assign d_type  = q_data[18:16];
  assign d_src   = q_data[31:24];
  assign d_pre   = (d_type == 3'd0) | (d_type == 3'd1) | (d_type == 3'd4) | (d_type == 3'd5);
  assign d_lim   = d_pre ? 9'(LIM_PRE) : 9'(LIM_NOPRE);
  assign d_over  = {1'b0, d_size} > d_lim;
  assign d_eff   = d_over ? d_lim[7:0] : d_size;
  assign d_words = ({1'b0, d_size} + 9'(BPW - 1)) >> BI_W;

  logic       in_body;
  logic [7:0] cur_byte;
  logic       tx_fire, q_fire;

  assign in_body  = (st == S_PRE) | (st == S_DATA);
  assign tx_valid = (st == S_HDR) | (in_body & wfull);
  assign q_ready  = (st == S_IDLE) | (st == S_DRAIN) | (in_body & ~wfull & (pop_left != 9'd0));
  assign cur_byte = (st == S_HDR) ? 8'(hdr >> {hcnt, 3'b000}) : 8'(wbuf >> {bidx, 3'b000});
  assign tx_data  = {~^cur_byte, cur_byte};
  assign tx_fire  = tx_valid & tx_ready;
  assign q_fire   = q_valid & q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hdr       <= '0;
      hcnt      <= '0;
      has_pre   <= 1'b0;
      wbuf      <= '0;
      wfull     <= 1'b0;
      bidx      <= '0;
      dleft     <= '0;
      pop_left  <= '0;
      trunc_err <= 1'b0;
    end else begin
      trunc_err <= 1'b0;
      case (st)
        S_IDLE: if (q_fire) begin
          hdr       <= {d_src, 5'b0, d_type, d_eff, d_dest};
          hcnt      <= '0;
          has_pre   <= d_pre;
          dleft     <= d_eff;
          pop_left  <= d_words + {8'd0, d_pre};
          trunc_err <= d_over;
          st        <= S_HDR;
        end
        S_HDR: if (tx_fire) begin
          hcnt <= hcnt + 2'd1;
          if (hcnt == 2'd3)
            st <= has_pre ? S_PRE : ((dleft != 8'd0) ? S_DATA : S_IDLE);
        end
        S_PRE, S_DATA: begin
          if (q_fire) begin
            wbuf     <= q_data;
            wfull    <= 1'b1;
            bidx     <= '0;
            pop_left <= pop_left - 9'd1;
          end else if (tx_fire) begin
            bidx <= bidx + 1'b1;
            if (st == S_PRE) begin
              if (bidx == BI_W'(BPW - 1)) begin
                wfull <= 1'b0;
                st    <= (dleft != 8'd0) ? S_DATA : ((pop_left != 9'd0) ? S_DRAIN : S_IDLE);
              end
            end else begin
              dleft <= dleft - 8'd1;
              if (bidx == BI_W'(BPW - 1) || dleft == 8'd1) wfull <= 1'b0;
              if (dleft == 8'd1) st <= (pop_left != 9'd0) ? S_DRAIN : S_IDLE;
            end
          end
        end
        S_DRAIN: if (q_fire) begin
          pop_left <= pop_left - 9'd1;
          if (pop_left == 9'd1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_tx_packer_chk.sv
module msg_tx_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       q_valid,
  input logic       q_ready,
  input logic [8:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       trunc_err
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !tx_valid && !trunc_err);

  assert_odd_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (^tx_data) == 1'b1);

  assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_no_pop_on_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !q_ready);

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_err |=> !trunc_err);

  assert_err_at_header_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_err |-> tx_valid && $past(q_valid && q_ready));
endmodule

bind msg_tx_packer msg_tx_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .trunc_err(trunc_err)
);

// File: tb/msg_tx_packer_tb.sv
module msg_tx_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] q_data = '0;
  logic        q_valid = 1'b0;
  logic        q_ready;
  logic [8:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        trunc_err;

  always #5 clk = ~clk;

  msg_tx_packer u_dut (
    .clk(clk), .rst_n(rst_n), .q_data(q_data), .q_valid(q_valid), .q_ready(q_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .trunc_err(trunc_err)
  );

  // {kind, size, dest, src, seed}
  localparam logic [39:0] VEC [0:10] = '{
    {8'd0, 8'd13,  8'h11, 8'h21, 8'h30},
    {8'd1, 8'd0,   8'h12, 8'h22, 8'h41},
    {8'd2, 8'd5,   8'h13, 8'h23, 8'h52},
    {8'd3, 8'd124, 8'h14, 8'h24, 8'h63},
    {8'd4, 8'd116, 8'h15, 8'h25, 8'h74},
    {8'd5, 8'd117, 8'h16, 8'h26, 8'h85},
    {8'd3, 8'd200, 8'h17, 8'h27, 8'h96},
    {8'd0, 8'd8,   8'h18, 8'h28, 8'hA7},
    {8'd2, 8'd0,   8'h19, 8'h29, 8'hB8},
    {8'd1, 8'd255, 8'h1A, 8'h2A, 8'hC9},
    {8'd4, 8'd1,   8'h1B, 8'h2B, 8'hDA}
  };

  logic [63:0] words [0:511];
  logic [7:0]  expb  [0:2047];
  logic [8:0]  rx    [0:2047];
  int msg_start [0:31], msg_len [0:31], msg_w0 [0:31], msg_w1 [0:31];
  int msg_kind [0:31], msg_size [0:31], err_seen [0:31];
  bit msg_trunc [0:31];
  int nmsg = 0, nwords = 0, nbytes = 0;
  int wi = 0, rx_cnt = 0;
  int checks = 0, failures = 0;
  int parity_bad = 0, hold_bad = 0, hold_seen = 0, err_bad = 0, gap_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_hold = 1'b0;
  logic [8:0] prev_data = '0;

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic add_msg(input int kind, input int size, input int dest, input int src, input int seed);
    bit pre;
    int lim, eff, nw;
    logic [63:0] addr, w;
    pre  = (kind == 0 || kind == 1 || kind == 4 || kind == 5);
    lim  = pre ? 116 : 124;
    eff  = (size > lim) ? lim : size;
    addr = {8{8'(seed)}} ^ 64'h0F1E2D3C4B5A6978;
    msg_start[nmsg] = nbytes; msg_w0[nmsg] = nwords;
    msg_kind[nmsg] = kind; msg_size[nmsg] = size;
    msg_trunc[nmsg] = (size > lim); err_seen[nmsg] = 0;
    words[nwords++] = {32'h0, 8'(src), 5'b0, 3'(kind), 8'(size), 8'(dest)};
    expb[nbytes++] = 8'(dest); expb[nbytes++] = 8'(eff);
    expb[nbytes++] = 8'(kind); expb[nbytes++] = 8'(src);
    if (pre) begin
      words[nwords++] = addr;
      for (int k = 0; k < 8; k++) expb[nbytes++] = addr[8*k +: 8];
    end
    nw = (size + 7) / 8;
    for (int j = 0; j < nw; j++) begin
      for (int l = 0; l < 8; l++)
        w[8*l +: 8] = (j*8 + l < size) ? 8'(seed + 7*(j*8 + l)) : 8'hA5;
      words[nwords++] = w;
    end
    for (int k = 0; k < eff; k++) expb[nbytes++] = 8'(seed + 7*k);
    msg_len[nmsg] = nbytes - msg_start[nmsg];
    msg_w1[nmsg] = nwords;
    nmsg++;
  endtask

  task automatic run(input int w_end, input int b_end, input int max_cyc, input bit stall);
    for (int c = 0; c < max_cyc; c++) begin
      if (wi >= w_end && rx_cnt >= b_end) break;
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      q_valid = (wi < w_end) && (!stall || lfsr[1] || lfsr[2]);
      q_data = q_valid ? words[wi] : 64'hDEAD_BEEF_0BAD_F00D;
      tx_ready = !stall || lfsr[4] || lfsr[7];
      if (trunc_err) tx_ready = 1'b0;
      #4;
      if (prev_hold) begin
        hold_seen++;
        if (!tx_valid || tx_data != prev_data) hold_bad++;
      end
      if (trunc_err) begin
        bit found = 1'b0;
        for (int m = 0; m < nmsg; m++)
          if (msg_start[m] == rx_cnt && tx_valid) begin err_seen[m]++; found = 1'b1; end
        if (!found) err_bad++;
      end
      if (!q_valid && q_ready && wi < w_end) gap_seen++;
      prev_hold = tx_valid && !tx_ready;
      prev_data = tx_data;
      if (q_valid && q_ready) wi++;
      if (tx_valid && tx_ready) begin
        if ((^tx_data) != 1'b1) parity_bad++;
        rx[rx_cnt++] = tx_data;
      end
    end
    @(negedge clk);
    q_valid = 1'b0;
    tx_ready = 1'b0;
  endtask

  task automatic check_msg(input int m);
    int bad = 0, first_act = 0, first_exp = 0;
    string tag;
    for (int k = 0; k < msg_len[m]; k++)
      if (rx[msg_start[m] + k][7:0] !== expb[msg_start[m] + k]) begin
        if (bad == 0) begin first_act = rx[msg_start[m] + k][7:0]; first_exp = expb[msg_start[m] + k]; end
        bad++;
      end
    tag = $sformatf("R2 %s R5%s%s",
      (msg_kind[m] == 2 || msg_kind[m] == 3) ? "R4" : "R3",
      msg_trunc[m] ? " R9" : "", (msg_size[m] == 0) ? " R11" : "");
    check(bad == 0, tag, $sformatf("msg %0d first wrong byte", m), first_act, first_exp);
  endtask

  task automatic check_err(input int lo, input int hi);
    for (int m = lo; m < hi; m++)
      check(err_seen[m] == (msg_trunc[m] ? 1 : 0), "R10", $sformatf("msg %0d error pulses", m),
            err_seen[m], msg_trunc[m] ? 1 : 0);
  endtask

  initial begin
    int a_end, b_end, x_msg, y_msg;
    repeat (3) @(negedge clk);
    #4;
    check(!tx_valid && !trunc_err, "R1", "outputs in reset", {tx_valid, trunc_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    #4;
    check(q_ready && !tx_valid && !trunc_err, "R1", "idle after reset", {q_ready, tx_valid, trunc_err}, 4);

    for (int v = 0; v < 11; v++)
      add_msg(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    a_end = nmsg;
    run(nwords, nbytes, 20000, 1'b0);
    for (int m = 0; m < a_end; m++) check_msg(m);
    check_err(0, a_end);

    for (int v = 0; v < 11; v++)
      add_msg(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    b_end = nmsg;
    run(nwords, nbytes, 60000, 1'b1);
    for (int m = a_end; m < b_end; m++) check_msg(m);
    check_err(a_end, b_end);
    check(rx_cnt == nbytes && wi == nwords && gap_seen > 0, "R8", "bytes out after queue gaps", rx_cnt, nbytes);
    check(hold_bad == 0 && hold_seen > 0, "R7", "held byte changes", hold_bad, 0);
    check(parity_bad == 0, "R6", "odd parity errors", parity_bad, 0);
    check(err_bad == 0, "R10", "misplaced error pulses", err_bad, 0);

    x_msg = nmsg;
    add_msg(4, 40, 8'h31, 8'h41, 8'h5C);
    run(msg_w1[x_msg], nbytes, 12, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    #4;
    check(!tx_valid && !trunc_err, "R1", "reset mid message", {tx_valid, trunc_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    wi = msg_w1[x_msg];
    prev_hold = 1'b0;
    y_msg = nmsg;
    add_msg(2, 3, 8'h32, 8'h42, 8'h6D);
    rx_cnt = msg_start[y_msg];
    run(nwords, nbytes, 2000, 1'b0);
    check_msg(y_msg);
    check(rx_cnt == nbytes, "R1", "fresh message after reset length", rx_cnt, nbytes);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule